// File: doc/BRIEF.md
# CAN Receive Message Buffer

This block holds received CAN frames for a processor to read. The bit-stream side of the controller writes each incoming frame one byte at a time, between a start strobe and a commit strobe. The bytes stay tentative until the commit. A frame that is abandoned part way is removed with an abort strobe, which moves the write position back to where that frame began. Committed frames are stored back to back as variable-length records in a circular byte store. Each record holds the header bytes followed by the data bytes.

The processor reads through a fixed window of register addresses. The window always shows the oldest stored frame. Its location depends on the frame format. Standard mode uses addresses 20 to 29, which is a 2-byte header plus up to 8 data bytes. Extended mode uses addresses 16 to 28, which is a 5-byte header plus up to 8 data bytes. A release strobe discards the oldest frame and shows the next one in the window.

A frame that does not fit into the free space is dropped and raises a sticky overrun flag. If the overrun interrupt is enabled, it also raises the interrupt. While the controller is in reset mode, every stored frame is flushed. Any frame under way is dropped, and nothing new is stored.

Top module: `can_rx_fifo`

## Requirements
- R1: A committed frame appears in the read window: window offset k returns the k-th byte written for the oldest frame, and `msg_cnt_o` goes up by one for each committed frame.
- R2: With `ext_mode_i`=0 the window covers addresses 20..29 (offset = address-20). With `ext_mode_i`=1 it covers 16..28 (offset = address-16). An address outside the window reads 0x00, and so does any read while no frame is stored.
- R3: Bytes of a frame that is not yet committed are invisible. An abort discards them without changing the message count or the frames already stored.
- R4: A release removes exactly the oldest frame, decrements `msg_cnt_o`, and shows the next frame at window offset 0.
- R5: A release while the message count is zero has no effect.
- R6: A frame longer than the free space (DEPTH, 64 by default, minus the stored bytes) is not stored. On its commit `overrun_o` rises and `msg_cnt_o` does not increase.
- R7: A frame whose length exactly equals the free space is stored without overrun.
- R8: `irq_o` rises on an overrun only when `ovr_irq_en_i` is 1. `clr_ovr_i` clears both `irq_o` and `overrun_o`.
- R9: While `reset_mode_i` is 1, the message count and the overrun flag are held at zero, and frames committed in that period are not stored.
- R10: A frame that was in progress when reset mode was entered is discarded, even if it is committed after reset mode ends. Storing resumes with the next start strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reset_mode_i | input | 1 | Controller reset mode; flushes the buffer |
| ext_mode_i | input | 1 | 1 selects the extended frame-format read window |
| wr_start_i | input | 1 | Start of a new frame |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to write |
| commit_i | input | 1 | Frame completed and valid |
| abort_i | input | 1 | Frame abandoned |
| release_i | input | 1 | Discard the oldest frame |
| clr_ovr_i | input | 1 | Clear overrun and interrupt |
| ovr_irq_en_i | input | 1 | Overrun interrupt enable |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 8 | Window byte at rd_addr_i |
| msg_cnt_o | output | 6 | Number of stored frames |
| overrun_o | output | 1 | Sticky overrun status |
| irq_o | output | 1 | Overrun interrupt |

## Verification
The hardest condition to reach from the ports is a buffer that is exactly full after records have wrapped around the end of the circular store. Only then do the exact-fit acceptance and the following overrun both depend on the fill count and on the pointer wrap. The stimulus first stores three extended frames of 5, 6 and 7 bytes and releases one. It then commits a 51-byte frame that fills the remaining space exactly. The next frame must overflow. A further release then checks that the window still lands on the right record after the wrap.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  localparam int unsigned ADDR_W       = 5;
  localparam int unsigned WIN_STD_BASE = 20;
  localparam int unsigned WIN_STD_LAST = 29;
  localparam int unsigned WIN_EXT_BASE = 16;
  localparam int unsigned WIN_EXT_LAST = 28;
endpackage

// File: rtl/can_rxf_store.sv
module can_rxf_store #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/can_rxf_lenq.sv
module can_rxf_lenq #(
  parameter int unsigned QDEPTH = 32,
  parameter int unsigned LW     = 7,
  localparam int unsigned PW    = $clog2(QDEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [LW-1:0] push_len_i,
  input  logic          pop_i,
  output logic [LW-1:0] head_len_o
);
  logic [LW-1:0] len_q [QDEPTH];
  logic [PW-1:0] head_q, tail_q;

  always_ff @(posedge clk_i) begin
    if (push_i) len_q[tail_q] <= push_len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop_i)  head_q <= head_q + 1'b1;
    end
  end

  assign head_len_o = len_q[head_q];
endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
  import can_rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LQD  = DEPTH / 2,
  localparam int unsigned CW   = $clog2(LQD) + 1,
  localparam int unsigned LW   = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reset_mode_i,
  input  logic              ext_mode_i,
  input  logic              wr_start_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              release_i,
  input  logic              clr_ovr_i,
  input  logic              ovr_irq_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [CW-1:0]     msg_cnt_o,
  output logic              overrun_o,
  output logic              irq_o
);
  logic [AW-1:0] rd_ptr_q, wr_ptr_q, fstart_q;
  logic [LW-1:0] used_q, flen_q, head_len;
  logic [CW-1:0] cnt_q;
  logic          fovr_q, fkill_q, ovr_q, irq_q;

  logic space_ok, wr_ok, wr_full, cmt_act, q_full, cmt_ok, cmt_ovr, rel_ok;

  assign space_ok = ({1'b0, used_q} + {1'b0, flen_q}) < (LW+1)'(DEPTH);
  assign wr_ok    = wr_en_i & ~reset_mode_i & ~fkill_q & ~fovr_q & space_ok;
  assign wr_full  = wr_en_i & ~reset_mode_i & ~fkill_q & ~space_ok;
  assign cmt_act  = commit_i & ~reset_mode_i & ~fkill_q;
  assign q_full   = (cnt_q == CW'(LQD));
  assign cmt_ok   = cmt_act & ~fovr_q & ~q_full & (flen_q != '0);
  assign cmt_ovr  = cmt_act & (fovr_q | q_full);
  assign rel_ok   = release_i & ~reset_mode_i & (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      fstart_q <= '0;
      used_q   <= '0;
      flen_q   <= '0;
      cnt_q    <= '0;
      fovr_q   <= 1'b0;
      fkill_q  <= 1'b0;
      ovr_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else if (reset_mode_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      fstart_q <= '0;
      used_q   <= '0;
      flen_q   <= '0;
      cnt_q    <= '0;
      fovr_q   <= 1'b0;
      fkill_q  <= 1'b1; // any frame in flight is void
      ovr_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_start_i) fkill_q <= 1'b0;

      if (cmt_ok) begin
        fstart_q <= wr_ptr_q;
        flen_q   <= '0;
      end else if (wr_start_i || abort_i || commit_i) begin
        wr_ptr_q <= fstart_q;
        flen_q   <= '0;
        fovr_q   <= 1'b0;
      end else if (wr_ok) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
        flen_q   <= flen_q + 1'b1;
      end else if (wr_full) begin
        fovr_q   <= 1'b1;
      end

      if (rel_ok) rd_ptr_q <= rd_ptr_q + head_len[AW-1:0];
      used_q <= used_q + (cmt_ok ? flen_q : '0) - (rel_ok ? head_len : '0);
      cnt_q  <= cnt_q + CW'(cmt_ok) - CW'(rel_ok);

      if (clr_ovr_i) begin
        ovr_q <= 1'b0;
        irq_q <= 1'b0;
      end
      if (cmt_ovr) begin
        ovr_q <= 1'b1;
        if (ovr_irq_en_i) irq_q <= 1'b1;
      end
    end
  end

  can_rxf_lenq #(.QDEPTH(LQD), .LW(LW)) lenq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (reset_mode_i),
    .push_i     (cmt_ok),
    .push_len_i (flen_q),
    .pop_i      (rel_ok),
    .head_len_o (head_len)
  );

  // read window
  logic [ADDR_W-1:0] win_base, win_last, win_off;
  logic              in_win;
  logic [AW-1:0]     raddr;
  logic [7:0]        mem_rdata;

  assign win_base = ext_mode_i ? ADDR_W'(WIN_EXT_BASE) : ADDR_W'(WIN_STD_BASE);
  assign win_last = ext_mode_i ? ADDR_W'(WIN_EXT_LAST) : ADDR_W'(WIN_STD_LAST);
  assign in_win   = (rd_addr_i >= win_base) && (rd_addr_i <= win_last);
  assign win_off  = rd_addr_i - win_base;
  assign raddr    = rd_ptr_q + AW'(win_off);

  can_rxf_store #(.DEPTH(DEPTH)) store_i (
    .clk_i   (clk_i),
    .we_i    (wr_ok),
    .waddr_i (wr_ptr_q),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  assign rd_data_o = (in_win && cnt_q != '0) ? mem_rdata : 8'h00;
  assign msg_cnt_o = cnt_q;
  assign overrun_o = ovr_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/can_rx_fifo_chk.sv
module can_rx_fifo_chk #(
  parameter int unsigned CW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reset_mode_i,
  input logic          commit_i,
  input logic          release_i,
  input logic          ovr_irq_en_i,
  input logic [CW-1:0] msg_cnt_o,
  input logic          overrun_o,
  input logic          irq_o
);
  a_r9_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_mode_i |=> (msg_cnt_o == '0) && !overrun_o && !irq_o);

  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && !commit_i && msg_cnt_o == '0) |=> msg_cnt_o == '0);

  a_r1_count_up_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !reset_mode_i) |=> msg_cnt_o <= $past(msg_cnt_o));

  a_r4_count_down_only_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!release_i && !reset_mode_i) |=> msg_cnt_o >= $past(msg_cnt_o));

  a_r8_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ovr_irq_en_i));

  a_r6_overrun_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> msg_cnt_o <= $past(msg_cnt_o));
endmodule

bind can_rx_fifo can_rx_fifo_chk #(.CW(CW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reset_mode_i (reset_mode_i),
  .commit_i     (commit_i),
  .release_i    (release_i),
  .ovr_irq_en_i (ovr_irq_en_i),
  .msg_cnt_o    (msg_cnt_o),
  .overrun_o    (overrun_o),
  .irq_o        (irq_o)
);

// File: tb/can_rx_fifo_tb_top.sv
module can_rx_fifo_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reset_mode = 0, ext_mode = 0, wr_start = 0, wr_en = 0, commit = 0, abort = 0;
  logic release_s = 0, clr_ovr = 0, irq_en = 0;
  logic [7:0] wr_data = '0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] msg_cnt;
  logic overrun, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reset_mode_i(reset_mode), .ext_mode_i(ext_mode),
    .wr_start_i(wr_start), .wr_en_i(wr_en), .wr_data_i(wr_data), .commit_i(commit),
    .abort_i(abort), .release_i(release_s), .clr_ovr_i(clr_ovr), .ovr_irq_en_i(irq_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .msg_cnt_o(msg_cnt),
    .overrun_o(overrun), .irq_o(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    #1;
  endtask

  task automatic put_bytes(int n, logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); wr_en = 1'b1; wr_data = seed + 8'(k);
    end
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  task automatic send_frame(int n, logic [7:0] seed);
    pulse(wr_start);
    put_bytes(n, seed);
    pulse(commit);
  endtask

  task automatic rd(logic [4:0] a, string req, int exp);
    rd_addr = a; #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset_state;
    check("R9 reset cnt", msg_cnt, 0);
    check("R9 reset ovr", overrun, 0);
    check("R8 reset irq", irq, 0);
    rd(5'd20, "R2 empty read", 0);
  endtask

  task automatic t_std_basic;
    ext_mode = 0;
    pulse(wr_start);
    put_bytes(5, 8'hA0);
    check("R3 uncommitted cnt", msg_cnt, 0);
    rd(5'd20, "R3 uncommitted invisible", 0);
    pulse(commit);
    check("R1 count after commit", msg_cnt, 1);
    rd(5'd20, "R1 std offset0", 8'hA0);
    rd(5'd21, "R2 std offset1", 8'hA1);
    rd(5'd24, "R1 std offset4", 8'hA4);
    rd(5'd19, "R2 below std window", 0);
    rd(5'd30, "R2 above std window", 0);
  endtask

  task automatic t_abort_release;
    pulse(wr_start);
    put_bytes(3, 8'h11);
    pulse(abort);
    check("R3 abort cnt", msg_cnt, 1);
    rd(5'd20, "R3 abort keeps oldest", 8'hA0);
    send_frame(2, 8'h77);
    check("R1 second commit", msg_cnt, 2);
    pulse(release_s);
    check("R4 release cnt", msg_cnt, 1);
    rd(5'd20, "R4 next frame visible", 8'h77);
    rd(5'd21, "R3 abort bytes not stored", 8'h78);
    pulse(release_s);
    check("R4 release to empty", msg_cnt, 0);
    pulse(release_s);
    check("R5 release at zero", msg_cnt, 0);
    rd(5'd20, "R5 empty window", 0);
  endtask

  task automatic t_ext_fill;
    ext_mode = 1;
    send_frame(5, 8'h10);
    send_frame(6, 8'h20);
    send_frame(7, 8'h30);
    check("R1 three ext frames", msg_cnt, 3);
    rd(5'd16, "R2 ext offset0", 8'h10);
    rd(5'd29, "R2 above ext window", 0);
    pulse(release_s);
    rd(5'd16, "R4 ext next frame", 8'h20);
    rd(5'd21, "R2 ext offset5", 8'h25);
    send_frame(51, 8'h40);
    check("R7 exact fill cnt", msg_cnt, 3);
    check("R7 exact fill no ovr", overrun, 0);
    send_frame(2, 8'hE0);
    check("R6 overflow cnt", msg_cnt, 3);
    check("R6 overrun set", overrun, 1);
    check("R8 irq disabled", irq, 0);
    pulse(release_s);
    rd(5'd16, "R6 window after drop", 8'h30);
    pulse(release_s);
    rd(5'd16, "R7 wrapped frame start", 8'h40);
    rd(5'd28, "R7 wrapped frame offset12", 8'h4C);
    pulse(clr_ovr);
    check("R8 clear ovr", overrun, 0);
  endtask

  task automatic t_irq;
    // 51 bytes stored, 13 free
    irq_en = 1;
    send_frame(14, 8'h60);
    check("R6 overflow by one", msg_cnt, 1);
    check("R8 irq set", irq, 1);
    pulse(clr_ovr);
    check("R8 irq cleared", irq, 0);
    check("R8 ovr cleared", overrun, 0);
    irq_en = 0;
  endtask

  task automatic t_reset_mode;
    ext_mode = 0;
    send_frame(4, 8'h90);
    @(negedge clk); reset_mode = 1;
    @(negedge clk); #1;
    check("R9 flush cnt", msg_cnt, 0);
    send_frame(3, 8'h55);
    check("R9 commit in reset", msg_cnt, 0);
    @(negedge clk); reset_mode = 0;
    pulse(wr_start);
    put_bytes(2, 8'hC0);
    @(negedge clk); reset_mode = 1;
    @(negedge clk); @(negedge clk); reset_mode = 0;
    put_bytes(2, 8'hC2);
    pulse(commit);
    check("R10 partial dropped", msg_cnt, 0);
    check("R10 no overrun", overrun, 0);
    send_frame(3, 8'hD0);
    check("R10 resume cnt", msg_cnt, 1);
    rd(5'd20, "R10 resume data", 8'hD0);
    rd(5'd22, "R10 resume offset2", 8'hD2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset_state;
    t_std_basic;
    t_abort_release;
    t_ext_fill;
    t_irq;
    t_reset_mode;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule